// File: doc/BRIEF.md
# Display DMA Interrupt Status Unit

This unit keeps the interrupt status flags for the DMA and pixel FIFO path of a display controller. It takes one-cycle event pulses from two DMA channels, from the pixel pin driver and from the AC-bias counter. Each event sets a sticky flag that software later clears by writing ones to it. One level interrupt request line stays high while any flag that may raise it is set.

In dual-panel mode the unit merges the channels' end-of-frame and branch reports, so each of those flags is set once per frame rather than once per channel. It also notes when a second frame-related interrupt arrives while one is already pending. It keeps the frame ID of the first pending interrupt in a read-only register. A small register port reads both registers and accepts write-one-to-clear writes to the status register.

Top module: `disp_irq_status`

## Requirements
- R1: Status register (address 0) bits: 0 output underrun, 1 quick-disable, 2 start-of-frame, 3 end-of-frame, 4 branch, 5 bus error, 6 AC-bias count, 7 subsequent interrupt. A bit stays set until a write to address 0 has a one in that position. A zero written to a bit leaves it unchanged.
- R2: `irq` is high exactly while some set status bit is allowed to raise it. `irq_mask[k]` = 1 blocks bit k for k = 0..4, and a masked bit does not raise `irq`.
- R3: Bits 5, 6 and 7 raise `irq` whatever the value of `irq_mask`.
- R4: Bit 7 is set when an unmasked bus-error, start-of-frame, end-of-frame or branch event occurs and either `irq` is already high or two or more such events arrive in the same cycle.
- R5: When no interrupt is pending and one of those four events occurs, the frame ID is latched. The ID comes from the channel that reported the bus error, else the channel that reported the start of frame, else channel 0. It reads back at address 1, does not change while `irq` is high, and ignores writes.
- R6: A branch and a start-of-frame arriving together, with nothing pending and no other event, set bits 4 and 2 but not bit 7.
- R7: A branch load sets bit 4 only when its branch-interrupt enable is high. A frame fetch end sets bit 3 only when its end-of-frame interrupt enable is high.
- R8: In dual-panel mode, bits 3 and 4 are set only once both channels have reported the qualified event, in the same cycle or in different cycles. The record of which channels have reported clears once the bit is set.
- R9: After `lcd_enable` falls, bit 1 is set on the first clock edge at which `burst_busy` is low.
- R10: Bit 0 is set when the pin driver reads an empty FIFO. In single-panel mode only channel 0 inputs count for any event. In dual-panel mode either channel counts.
- R11: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 1 = dual-panel operation |
| irq_mask | input | 5 | Mask bits for status bits 0..4, 1 = masked |
| ch_sof | input | 2 | Start-of-frame pulse per channel |
| ch_eof_done | input | 2 | Frame fetch completed, per channel |
| ch_eof_ie | input | 2 | End-of-frame interrupt enable of the descriptor, per channel |
| ch_br_done | input | 2 | Branch descriptor loaded, per channel |
| ch_br_ie | input | 2 | Branch interrupt enable, per channel |
| ch_bus_err | input | 2 | Bus error pulse per channel |
| ch_fid0 | input | FID_W | Current frame ID of channel 0 |
| ch_fid1 | input | FID_W | Current frame ID of channel 1 |
| fifo_empty_rd | input | 2 | Pin driver read an empty FIFO, per FIFO |
| ac_bias_evt | input | 1 | AC-bias transition count reached |
| lcd_enable | input | 1 | Controller enable |
| burst_busy | input | 1 | A DMA data burst is in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = frame ID |
| reg_wdata | input | 8 | Write data, ones clear status bits |
| rd_data | output | FID_W | Read data for `reg_addr` |
| status_o | output | 8 | Current status register |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can act on one status bit in the same cycle: a hardware set and a software write-one clear. The bench provokes this by pulsing an underrun while it writes a clear mask that covers that bit and the bus-error bit. It expects the underrun bit to stay set and the bus-error bit to be cleared. The bench also fires several event classes in one cycle. With nothing pending, the branch plus start-of-frame pair must not set the subsequent flag, while the bus-error plus start-of-frame pair must set it.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int ST_W   = 8;
  localparam int MSK_W  = 5;
  localparam int ST_OU  = 0;
  localparam int ST_QD  = 1;
  localparam int ST_SOF = 2;
  localparam int ST_EOF = 3;
  localparam int ST_BR  = 4;
  localparam int ST_BE  = 5;
  localparam int ST_ABC = 6;
  localparam int ST_SUB = 7;

  // cls bit order: [3] branch, [2] end-of-frame, [1] start-of-frame, [0] bus error
  function automatic logic sub_needed(input logic [3:0] cls, input logic pend);
    logic multi;
    logic pair_only;
    multi     = ($countones(cls) >= 2);
    pair_only = (cls == 4'b1010);
    return (|cls) && (pend || (multi && !pair_only));
  endfunction

  function automatic logic [ST_W-1:0] irq_enables(input logic [MSK_W-1:0] msk);
    return {3'b111, ~msk};
  endfunction
endpackage

// File: rtl/dis_dual_merge.sv
module dis_dual_merge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dual,
  input  logic [1:0] ev,
  output logic       hit
);
  logic [1:0] seen_q;
  logic [1:0] arr;

  always_comb begin
    arr = seen_q | ev;
    hit = dual ? (&arr) : ev[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen_q <= '0;
    else if (!dual || hit) seen_q <= '0;
    else                   seen_q <= arr;
  end
endmodule

// File: rtl/dis_qd_tracker.sv
module dis_qd_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic lcd_enable,
  input  logic burst_busy,
  output logic qd_evt
);
  logic en_q;
  logic armed_q;
  logic armed_n;

  always_comb begin
    armed_n = armed_q | (en_q & ~lcd_enable);
    qd_evt  = armed_n & ~burst_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_q    <= lcd_enable;
      armed_q <= armed_n & burst_busy;
    end
  end
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import dis_pkg::*;
#(
  parameter int FID_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dual_mode,
  input  logic [MSK_W-1:0]      irq_mask,
  input  logic [1:0]            ch_sof,
  input  logic [1:0]            ch_eof_done,
  input  logic [1:0]            ch_eof_ie,
  input  logic [1:0]            ch_br_done,
  input  logic [1:0]            ch_br_ie,
  input  logic [1:0]            ch_bus_err,
  input  logic [FID_W-1:0]      ch_fid0,
  input  logic [FID_W-1:0]      ch_fid1,
  input  logic [1:0]            fifo_empty_rd,
  input  logic                  ac_bias_evt,
  input  logic                  lcd_enable,
  input  logic                  burst_busy,
  input  logic                  reg_wr,
  input  logic                  reg_addr,
  input  logic [ST_W-1:0]       reg_wdata,
  output logic [FID_W-1:0]      rd_data,
  output logic [ST_W-1:0]       status_o,
  output logic                  irq
);
  localparam int NMRG = 2;

  logic [ST_W-1:0]  status_q;
  logic [ST_W-1:0]  set_vec;
  logic [ST_W-1:0]  clr_vec;
  logic [FID_W-1:0] fid_q;
  logic [FID_W-1:0] fid_pick;
  logic [1:0]       ch_live;
  logic [1:0]       mrg_in [NMRG];
  logic [NMRG-1:0]  mrg_hit;
  logic [3:0]       cls;
  logic [MSK_W-1:0] unm;
  logic             pending;
  logic             fid_cap;
  logic             qd_evt;
  logic             sub_set;

  assign ch_live   = dual_mode ? 2'b11 : 2'b01;
  assign mrg_in[0] = ch_eof_done & ch_eof_ie;
  assign mrg_in[1] = ch_br_done & ch_br_ie;

  for (genvar g = 0; g < NMRG; g++) begin : g_mrg
    dis_dual_merge u_mrg (
      .clk  (clk),
      .rst_n(rst_n),
      .dual (dual_mode),
      .ev   (mrg_in[g]),
      .hit  (mrg_hit[g])
    );
  end

  dis_qd_tracker u_qd (
    .clk       (clk),
    .rst_n     (rst_n),
    .lcd_enable(lcd_enable),
    .burst_busy(burst_busy),
    .qd_evt    (qd_evt)
  );

  assign pending = irq;

  always_comb begin
    set_vec         = '0;
    set_vec[ST_OU]  = |(fifo_empty_rd & ch_live);
    set_vec[ST_QD]  = qd_evt;
    set_vec[ST_SOF] = |(ch_sof & ch_live);
    set_vec[ST_EOF] = mrg_hit[0];
    set_vec[ST_BR]  = mrg_hit[1];
    set_vec[ST_BE]  = |(ch_bus_err & ch_live);
    set_vec[ST_ABC] = ac_bias_evt;
    unm             = set_vec[MSK_W-1:0] & ~irq_mask;
    cls             = {unm[ST_BR], unm[ST_EOF], unm[ST_SOF], set_vec[ST_BE]};
    sub_set         = sub_needed(cls, pending);
    set_vec[ST_SUB] = sub_set;
    clr_vec         = (reg_wr && !reg_addr) ? reg_wdata : '0;
    fid_cap         = !pending && (|cls);
  end

  always_comb begin
    if (cls[0])      fid_pick = (ch_bus_err[0] || !dual_mode) ? ch_fid0 : ch_fid1;
    else if (cls[1]) fid_pick = (ch_sof[0] || !dual_mode) ? ch_fid0 : ch_fid1;
    else             fid_pick = ch_fid0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      fid_q    <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (fid_cap) fid_q <= fid_pick;
    end
  end

  assign irq      = |(status_q & irq_enables(irq_mask));
  assign status_o = status_q;
  assign rd_data  = reg_addr ? fid_q : FID_W'(status_q);
endmodule

// File: rtl/dis_irq_checker.sv
module dis_irq_checker
  import dis_pkg::*;
#(
  parameter int FID_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ST_W-1:0]  status_q,
  input logic [ST_W-1:0]  set_vec,
  input logic [ST_W-1:0]  clr_vec,
  input logic [MSK_W-1:0] irq_mask,
  input logic [FID_W-1:0] fid_q,
  input logic             pending,
  input logic             irq
);
  // R1: a set bit that was not written with one stays set
  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q) & ~$past(clr_vec)) & ~status_q) == '0);

  // R11: a bit set by hardware is set on the next cycle, whatever the write did
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_vec) & ~status_q) == '0));

  // R2: nothing enabled -> no request
  assert_irq_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (((status_q[MSK_W-1:0] & ~irq_mask) == '0) && (status_q[ST_W-1:MSK_W] == '0)) |-> !irq);

  // R3: unmaskable bits always request
  assert_unmaskable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[ST_BE] || status_q[ST_ABC] || status_q[ST_SUB]) |-> irq);

  // R5: captured frame ID holds while an interrupt is pending
  assert_fid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> $stable(fid_q));

  // R6: branch plus start-of-frame alone, nothing pending, leaves subsequent flag clear
  assert_pair_no_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && set_vec[ST_SOF] && set_vec[ST_BR] && !set_vec[ST_EOF]
     && !set_vec[ST_BE] && !status_q[ST_SUB]) |=> !status_q[ST_SUB]);
endmodule

bind disp_irq_status dis_irq_checker #(.FID_W(FID_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .status_q(status_q),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .irq_mask(irq_mask),
  .fid_q   (fid_q),
  .pending (pending),
  .irq     (irq)
);

// File: tb/sim_disp_irq_status.sv
module sim_disp_irq_status;
  localparam int CLK_P = 10;
  localparam int FID_W = 32;
  localparam int NV    = 23;

  typedef struct packed {
    logic       dual;
    logic [4:0] msk;
    logic [1:0] sof;
    logic [1:0] eof;
    logic [1:0] eie;
    logic [1:0] br;
    logic [1:0] bie;
    logic [1:0] be;
    logic [1:0] und;
    logic       abc;
    logic       wr;
    logic [7:0] wd;
    logic [7:0] exp;
    logic       eirq;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0,5'h00,2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h04,1'b1}, // 0 R1 SOF sets
    '{1'b0,5'h00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'h04,8'h00,1'b0}, // 1 R1 clear
    '{1'b0,5'h00,2'b00,2'b00,2'b00,2'b01,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h00,1'b0}, // 2 R7 branch not enabled
    '{1'b0,5'h00,2'b01,2'b00,2'b00,2'b01,2'b01,2'b00,2'b00,1'b0,1'b0,8'h00,8'h14,1'b1}, // 3 R6 pair no sub
    '{1'b0,5'h00,2'b00,2'b01,2'b01,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h9C,1'b1}, // 4 R4 while pending
    '{1'b0,5'h00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'h9C,8'h00,1'b0}, // 5 R1
    '{1'b0,5'h1F,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,1'b0,1'b0,8'h00,8'h01,1'b0}, // 6 R10 R2 masked underrun
    '{1'b0,5'h1F,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b1,1'b0,8'h00,8'h41,1'b1}, // 7 R3 ABC unmaskable
    '{1'b0,5'h1F,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'h40,8'h01,1'b0}, // 8 R1 zero no effect
    '{1'b0,5'h1F,2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,2'b00,1'b0,1'b0,8'h00,8'h21,1'b1}, // 9 R3 bus error
    '{1'b0,5'h1F,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,1'b0,1'b1,8'h21,8'h01,1'b0}, // 10 R11 set wins
    '{1'b0,5'h00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h01,1'b1}, // 11 R2 unmask
    '{1'b0,5'h00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'h01,8'h00,1'b0}, // 12 R1
    '{1'b1,5'h00,2'b00,2'b01,2'b11,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h00,1'b0}, // 13 R8 half
    '{1'b1,5'h00,2'b00,2'b10,2'b11,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h08,1'b1}, // 14 R8 both
    '{1'b1,5'h00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'h08,8'h00,1'b0}, // 15 R1
    '{1'b1,5'h00,2'b00,2'b10,2'b10,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h00,1'b0}, // 16 R8 record cleared
    '{1'b1,5'h00,2'b00,2'b10,2'b10,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h00,1'b0}, // 17 R8 same channel twice
    '{1'b1,5'h00,2'b00,2'b01,2'b01,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h08,1'b1}, // 18 R8
    '{1'b0,5'h00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'h08,8'h00,1'b0}, // 19 R1
    '{1'b0,5'h00,2'b10,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,8'h00,8'h00,1'b0}, // 20 R10 ch1 ignored
    '{1'b0,5'h00,2'b01,2'b00,2'b00,2'b00,2'b00,2'b01,2'b00,1'b0,1'b0,8'h00,8'hA4,1'b1}, // 21 R4 two at once
    '{1'b0,5'h00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,8'hA4,8'h00,1'b0}  // 22 R1
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dual_mode = 1'b0;
  logic [4:0]       irq_mask = '0;
  logic [1:0]       ch_sof = '0, ch_eof_done = '0, ch_eof_ie = '0;
  logic [1:0]       ch_br_done = '0, ch_br_ie = '0, ch_bus_err = '0, fifo_empty_rd = '0;
  logic [FID_W-1:0] ch_fid0 = '0, ch_fid1 = '0;
  logic             ac_bias_evt = 1'b0, lcd_enable = 1'b1, burst_busy = 1'b0;
  logic             reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0]       reg_wdata = '0;
  logic [FID_W-1:0] rd_data;
  logic [7:0]       status_o;
  logic             irq;
  int               n_chk = 0;
  int               n_bad = 0;
  bit               done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  disp_irq_status #(.FID_W(FID_W)) u0 (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .irq_mask(irq_mask),
    .ch_sof(ch_sof), .ch_eof_done(ch_eof_done), .ch_eof_ie(ch_eof_ie),
    .ch_br_done(ch_br_done), .ch_br_ie(ch_br_ie), .ch_bus_err(ch_bus_err),
    .ch_fid0(ch_fid0), .ch_fid1(ch_fid1), .fifo_empty_rd(fifo_empty_rd),
    .ac_bias_evt(ac_bias_evt), .lcd_enable(lcd_enable), .burst_busy(burst_busy),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .status_o(status_o), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    ch_sof = '0; ch_eof_done = '0; ch_eof_ie = '0; ch_br_done = '0; ch_br_ie = '0;
    ch_bus_err = '0; fifo_empty_rd = '0; ac_bias_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    quiet();
  endtask

  task automatic clear_all();
    @(negedge clk);
    reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = 8'hFF;
    step();
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", 32'(status_o), 32'h0);
    chk("R2 reset irq", 32'(irq), 32'h0);
    reg_addr = 1'b1;
    #1 chk("R5 reset frame id", rd_data, 32'h0);
    reg_addr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dual_mode = TBL[i].dual; irq_mask = TBL[i].msk;
      ch_sof = TBL[i].sof; ch_eof_done = TBL[i].eof; ch_eof_ie = TBL[i].eie;
      ch_br_done = TBL[i].br; ch_br_ie = TBL[i].bie; ch_bus_err = TBL[i].be;
      fifo_empty_rd = TBL[i].und; ac_bias_evt = TBL[i].abc;
      reg_addr = 1'b0; reg_wr = TBL[i].wr; reg_wdata = TBL[i].wd;
      step();
      chk($sformatf("vector %0d status", i), 32'(status_o), 32'(TBL[i].exp));
      chk($sformatf("vector %0d irq", i), 32'(irq), 32'(TBL[i].eirq));
    end

    // R5: capture on first pending interrupt, hold while pending, ignore writes
    dual_mode = 1'b0; irq_mask = '0;
    ch_fid0 = 32'h1111_1111; ch_fid1 = 32'h2222_2222;
    @(negedge clk); ch_sof = 2'b01; step();
    reg_addr = 1'b1; #1 chk("R5 first capture", rd_data, 32'h1111_1111);
    ch_fid0 = 32'h3333_3333;
    @(negedge clk); reg_addr = 1'b0; ch_eof_done = 2'b01; ch_eof_ie = 2'b01; step();
    reg_addr = 1'b1; #1 chk("R5 held while pending", rd_data, 32'h1111_1111);
    @(negedge clk); reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = 8'hFF; step();
    reg_addr = 1'b1; #1 chk("R5 write ignored", rd_data, 32'h1111_1111);
    chk("R5 write to id leaves status", 32'(status_o), 32'h8C);
    clear_all();
    dual_mode = 1'b1;
    @(negedge clk); ch_bus_err = 2'b10; step();
    reg_addr = 1'b1; #1 chk("R5 bus error channel 1 id", rd_data, 32'h2222_2222);
    reg_addr = 1'b0;
    chk("R10 dual channel 1 counts", 32'(status_o), 32'h20);
    clear_all();
    dual_mode = 1'b0;

    // R9: quick disable waits for the burst to end
    @(negedge clk); lcd_enable = 1'b0; burst_busy = 1'b1; step();
    chk("R9 burst still running", 32'(status_o[1]), 32'h0);
    step();
    chk("R9 burst still running 2", 32'(status_o[1]), 32'h0);
    burst_busy = 1'b0; step();
    chk("R9 set after burst", 32'(status_o[1]), 32'h1);
    chk("R9 irq", 32'(irq), 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule